// File: doc/BRIEF.md
# DLL Shift-Then-SAR Lock Controller

This block is the digital control logic of a successive-approximation delay-locked loop. Each clock is one reference cycle. In that cycle the block reads one early/late decision from an external phase detector and drives a binary control word to an external delay line. A higher word means a longer delay. The decision input reads "late" when the current delay is too long.

Locking has two phases. First a doubling search starts from the smallest nonzero word and moves a single set bit one place to the left on each short decision. The first long decision marks the overshoot, and the bit below it becomes the most significant bit of the answer. Because the search climbs from the smallest delay, it cannot settle on a multiple of the reference period. A binary search then resolves only the bits below that position, one bit per cycle. When that search ends, the locked flag rises.

While locked, a monitor counts consecutive identical decisions. When a run reaches a programmable length, the controller restarts the whole sequence. This lets the loop lock again after drift, where a plain successive-approximation controller locks only once.

Top module: `dll_sar_lock_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released, ctrl_word_o is 1, locked_o is 0 and state_o is 00 (doubling search).
- R2: While state_o is 00, ctrl_word_o always has exactly one bit set. Each short decision (pd_late_i = 0) shifts that bit one place left on the next clock.
- R3: In the doubling search, the first long decision at set bit k (k >= 1) ends the search. Bit k-1 becomes the highest set bit of the result and no higher bit is ever set afterwards. A long decision at k = 0 locks with word 0. A short decision at the top bit (CW-1) makes CW-1 the highest bit.
- R4: In the binary search (state_o 01), one bit is tried per cycle, from high to low. A tried bit is kept on a short decision and cleared on a long one. Bits above the tried bit never change.
- R5: The locked word is the largest value whose decision is short. For an ideal detector that is min(target, 2^CW-1). It is 0 when even a word of 1 is long.
- R6: Counted in clocks from the start of a search, lock arrives after 1 clock when the word 1 is already long. Otherwise it arrives after 2k clocks, where k is the overshoot bit, or after 2*CW-1 clocks if no overshoot occurs.
- R7: state_o is 10 exactly when locked_o is 1. locked_o stays 0 during the whole of any search, including a restarted one.
- R8: While locked, loss_thresh_i identical decisions in a row (a value of 0 acts as 1) return the controller on the next clock to state 00 with word 1 and locked_o low. Runs shorter than that threshold, such as alternating decisions, keep the lock indefinitely.
- R9: After a restart, the controller locks to the new delay target with the same result and timing as from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference-cycle clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pd_late_i | input | 1 | Phase detector decision: 1 = delay too long, 0 = too short |
| loss_thresh_i | input | CNT_W | Length of an identical-decision run that counts as loss of lock |
| ctrl_word_o | output | CW | Delay-line control word |
| locked_o | output | 1 | Lock achieved |
| state_o | output | 2 | 00 doubling, 01 binary search, 10 locked |

## Verification
A corrupted search register shows first in the lock time: a wrong shift or a skipped bit changes the clock count to lock, which the bench compares against the 2k formula on every relock. A wrong kept or cleared bit appears as a locked word that differs from min(target, 2^CW-1) at the first locked cycle. A broken loss counter shows within the threshold number of cycles, either as an early drop of locked_o under alternating decisions or as a missed restart when the target moves or the word saturates.

// File: rtl/dll_sar_pkg.sv
package dll_sar_pkg;
  typedef enum logic [1:0] {
    ST_DOUBLE = 2'b00,
    ST_BINARY = 2'b01,
    ST_LOCKED = 2'b10
  } dll_state_e;
endpackage

// File: rtl/dll_next_step.sv
module dll_next_step
  import dll_sar_pkg::*;
#(
  parameter int CW = 12,
  localparam int IW = $clog2(CW)
) (
  input  dll_state_e    state_i,
  input  logic [CW-1:0] word_i,
  input  logic [IW-1:0] idx_i,
  input  logic          late_i,
  input  logic          loss_i,
  output dll_state_e    state_o,
  output logic [CW-1:0] word_o,
  output logic [IW-1:0] idx_o
);
  localparam logic [IW-1:0] TOP = IW'(CW - 1);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] kept;

  always_comb begin
    state_o = state_i;
    word_o  = word_i;
    idx_o   = idx_i;
    kept    = late_i ? (word_i & ~(ONE << idx_i)) : word_i;
    unique case (state_i)
      ST_DOUBLE: begin
        if (late_i) begin
          if (idx_i == '0) begin
            word_o  = '0;
            state_o = ST_LOCKED;
          end else if (idx_i == IW'(1)) begin
            word_o  = ONE;
            state_o = ST_LOCKED;
          end else begin
            // previous bit is the MSB, try the one below it next
            word_o  = (ONE << (idx_i - IW'(1))) | (ONE << (idx_i - IW'(2)));
            idx_o   = idx_i - IW'(2);
            state_o = ST_BINARY;
          end
        end else if (idx_i == TOP) begin
          word_o  = (ONE << (CW - 1)) | (ONE << (CW - 2));
          idx_o   = IW'(CW - 2);
          state_o = ST_BINARY;
        end else begin
          word_o = word_i << 1;
          idx_o  = idx_i + IW'(1);
        end
      end
      ST_BINARY: begin
        if (idx_i == '0) begin
          word_o  = kept;
          state_o = ST_LOCKED;
        end else begin
          word_o = kept | (ONE << (idx_i - IW'(1)));
          idx_o  = idx_i - IW'(1);
        end
      end
      ST_LOCKED: begin
        if (loss_i) begin
          word_o  = ONE;
          idx_o   = '0;
          state_o = ST_DOUBLE;
        end
      end
      default: begin
        word_o  = ONE;
        idx_o   = '0;
        state_o = ST_DOUBLE;
      end
    endcase
  end
endmodule

// File: rtl/dll_loss_mon.sv
module dll_loss_mon #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             late_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic             loss_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             prev_q;
  logic [CNT_W:0]   run_n;

  always_comb begin
    run_n  = (cnt_q != '0 && late_i == prev_q) ? {1'b0, cnt_q} + 1'b1 : (CNT_W+1)'(1);
    loss_o = active_i && (run_n >= {1'b0, thresh_i});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      prev_q <= late_i;
      if (!active_i || loss_o) cnt_q <= '0;
      else                     cnt_q <= run_n[CNT_W-1:0];
    end
  end

  // R8
  run_below_thresh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && thresh_i != '0 && $stable(thresh_i)) |-> (cnt_q < thresh_i));
endmodule

// File: rtl/dll_sar_lock_ctrl.sv
module dll_sar_lock_ctrl
  import dll_sar_pkg::*;
#(
  parameter int CW    = 12,
  parameter int CNT_W = 6,
  localparam int IW   = $clog2(CW)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_late_i,
  input  logic [CNT_W-1:0] loss_thresh_i,
  output logic [CW-1:0]    ctrl_word_o,
  output logic             locked_o,
  output logic [1:0]       state_o
);
  dll_state_e    state_q, state_n;
  logic [CW-1:0] word_q, word_n;
  logic [IW-1:0] idx_q, idx_n;
  logic          locked_q;
  logic          loss;

  dll_loss_mon #(.CNT_W(CNT_W)) u_mon (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (state_q == ST_LOCKED),
    .late_i   (pd_late_i),
    .thresh_i (loss_thresh_i),
    .loss_o   (loss)
  );

  dll_next_step #(.CW(CW)) u_step (
    .state_i (state_q),
    .word_i  (word_q),
    .idx_i   (idx_q),
    .late_i  (pd_late_i),
    .loss_i  (loss),
    .state_o (state_n),
    .word_o  (word_n),
    .idx_o   (idx_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_DOUBLE;
      word_q   <= CW'(1);
      idx_q    <= '0;
      locked_q <= 1'b0;
    end else begin
      state_q  <= state_n;
      word_q   <= word_n;
      idx_q    <= idx_n;
      locked_q <= (state_n == ST_LOCKED);
    end
  end

  assign ctrl_word_o = word_q;
  assign locked_o    = locked_q;
  assign state_o     = state_q;

  // R2
  double_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DOUBLE) |-> ($countones(word_q) == 1));

  // R4
  binary_upper_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BINARY && $past(state_q) == ST_BINARY)
      |-> (((word_q ^ $past(word_q)) >> ($past(idx_q) + 1'b1)) == '0));

  // R3
  binary_no_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BINARY) |=> (state_q != ST_DOUBLE));

  // R7
  locked_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o == (state_q == ST_LOCKED));

  // R8
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loss |=> (state_q == ST_DOUBLE && word_q == CW'(1) && !locked_o));
endmodule

// File: tb/dll_sar_lock_ctrl_test.sv
module dll_sar_lock_ctrl_test;
  localparam int CW    = 12;
  localparam int CNT_W = 6;
  localparam int MAXW  = (1 << CW) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tog = 1'b0;
  logic [CNT_W-1:0] thresh = 6'd4;
  int               target = 341;
  logic [CW-1:0]    word;
  logic             locked;
  logic [1:0]       state;
  logic             pd_late;
  int               checks = 0;
  int               errors = 0;

  always #4 clk = ~clk;
  always @(posedge clk) tog <= ~tog;

  // ideal detector; alternates at the exact point only once locked
  assign pd_late = (int'(word) > target) || (locked && int'(word) == target && tog);

  dll_sar_lock_ctrl #(.CW(CW), .CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pd_late_i(pd_late), .loss_thresh_i(thresh),
    .ctrl_word_o(word), .locked_o(locked), .state_o(state)
  );

  function automatic int exp_word(int t);
    return (t > MAXW) ? MAXW : t;
  endfunction

  function automatic int exp_cycles(int t);
    int p;
    if (t == 0) return 1;
    p = 0;
    for (int i = 0; i < 31; i++) if ((t >> i) & 1) p = i;
    if (p >= CW - 1) return 2 * CW - 1;
    return 2 * p + 2;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_lock(output int n);
    bit onehot_ok = 1'b1;
    n = 0;
    do begin
      tick();
      n++;
      if (state == 2'b00 && $countones(word) != 1) onehot_ok = 1'b0;
      if (state != 2'b10 && locked) onehot_ok = 1'b0;
    end while (!locked && n < 200);
    check(onehot_ok, "R2 single set bit in doubling / R7 no early lock", int'(word), 0);
  endtask

  task automatic relock(int t, logic [CNT_W-1:0] th);
    int n, m, lim;
    thresh = th;
    target = t;
    lim = (th == 0) ? 1 : int'(th);
    n = 0;
    while (locked && n < 100) begin
      tick();
      n++;
    end
    check(n >= 1 && n <= lim, "R8 restart within threshold", n, lim);
    check(word == CW'(1) && state == 2'b00, "R8 restart state", int'(word), 1);
    wait_lock(m);
    check(m == exp_cycles(t), "R6/R9 lock cycles", m, exp_cycles(t));
    check(int'(word) == exp_word(t), "R5/R9 locked word", int'(word), exp_word(t));
    check(state == 2'b10 && locked, "R7 locked state", int'(state), 2);
    if (t <= MAXW) begin
      bit held = 1'b1;
      for (int i = 0; i < 4 * lim + 6; i++) begin
        tick();
        if (!locked) held = 1'b0;
      end
      check(held, "R8 alternating decisions keep lock", int'(locked), 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, t;
    int dir[10] = '{0, 1, 2, 3, 7, 2748, 2048, 4095, 100, 5};
    repeat (3) tick();
    check(word == CW'(1) && !locked && state == 2'b00, "R1 reset state", int'(word), 1);
    rst_n = 1'b1;
    check(word == CW'(1) && !locked && state == 2'b00, "R1 after release", int'(word), 1);
    wait_lock(n);
    check(n == exp_cycles(341), "R6 lock cycles from reset", n, exp_cycles(341));
    check(int'(word) == 341, "R5 locked word from reset", int'(word), 341);

    foreach (dir[i]) relock(dir[i], 6'd3);

    void'($urandom(32'd1234));
    for (int i = 0; i < 24; i++) begin
      t = int'($urandom % 4096);
      if (t == int'(word)) t = (t + 1) % 4096;
      relock(t, CNT_W'(2 + $urandom % 5));
    end

    // saturation: word pinned below target, every decision short (R3, R5, R8)
    relock(5000, 6'd5);
    n = 0;
    while (locked && n < 100) begin
      n++;
      tick();
    end
    check(n == 5, "R8 exact run length at saturation", n, 5);
    check(word == CW'(1) && state == 2'b00 && !locked, "R8 word and state after loss", int'(word), 1);

    thresh = '0;
    wait_lock(n);
    check(n == 2 * CW - 1 && int'(word) == MAXW, "R3 top-bit path cycles", n, 2 * CW - 1);
    n = 0;
    while (locked && n < 100) begin
      n++;
      tick();
    end
    check(n == 1, "R8 zero threshold acts as one", n, 1);

    // reset in mid-search
    thresh = 6'd4;
    target = 1000;
    repeat (5) tick();
    rst_n = 1'b0;
    tick();
    check(word == CW'(1) && !locked && state == 2'b00, "R1 reset during search", int'(word), 1);
    rst_n = 1'b1;
    wait_lock(n);
    check(n == exp_cycles(1000) && int'(word) == 1000, "R9 lock after mid-search reset", n, exp_cycles(1000));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule